// File: doc/BRIEF.md
# Byte-Wide Digital Port with Falling-Edge Interrupt

The block drives and senses eight general-purpose pins through two host-visible byte registers. A data register at offset 3 holds the value driven on pins that are configured as outputs. When it is read, each bit shows the live pin level if that bit is an input, or the driven value if that bit is an output. A control register at offset 4 holds two direction bits, one for each nibble of the port, an interrupt enable, and a sticky interrupt-request flag. The host can read all of these bits back.

A falling edge on the external interrupt input sets the request flag if the enable is on. The input passes through two flops to synchronise it before the edge is detected. The flag stays set until the host reads offset 1. A host write can neither set nor clear the flag. The block's interrupt line is high when the flag and the enable are both set. The pad cells that turn the output-enable and output-value signals into tristate drivers are outside this block.

Top module: `dio_irq_port`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are 0, the control register reads 0x00 and `irq_out` is 0.
- R2: A write at offset 3 loads `wdata[i]` into `pin_out[i]` only where `pin_oe[i]` is 1. Bits configured as inputs keep their previous driven value.
- R3: The read data at offset 3 has `pin_in[i]` in each bit whose `pin_oe[i]` is 0, and `pin_out[i]` in each bit whose `pin_oe[i]` is 1.
- R4: The control register at offset 4 uses these bit positions: bit 0 is the low-nibble direction, bit 1 is the high-nibble direction, bit 2 is the interrupt enable and bit 3 is the request flag. Bits 7..4 read 0. A write sets bits 0..2, and every written value reads back.
- R5: `pin_oe[3:0]` all equal control bit 0 and `pin_oe[7:4]` all equal control bit 1. A value of 1 means output.
- R6: While the enable is set, a 1-to-0 transition on `irq_in` sets the request flag on the third rising clock edge after the transition. A rising transition does not set the flag, and neither does any transition while the enable is clear.
- R7: A read at offset 1 clears the request flag. A write at offset 4 leaves bit 3 unchanged, whether `wdata[3]` is 0 or 1.
- R8: If a synchronised falling edge and a clearing read at offset 1 occur in the same cycle, the flag remains set.
- R9: `irq_out` is 1 exactly when the request flag and the enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 8 | Sensed pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin driven value |
| irq_in | input | 1 | External interrupt input, asynchronous |
| irq_out | output | 1 | Interrupt request to the host |

## Verification
A wrong latched output bit appears at `pin_out` on the edge after the write that caused it. It also appears in the offset-3 readback, but only for bits configured as outputs. A corrupted direction bit is visible at once on four bits of `pin_oe`, and it also changes which source the readback shows for those bits. A fault in the flag logic shows up at `irq_out` and in control bit 3. The symptom is either a flag that fails to rise on the third edge after a falling input, or a flag that survives a clearing read, or one that is lost to that read when an edge coincides with it. The mismatch is observable within one to three cycles of the event.

// File: rtl/dio_irq_port.sv
module dio_irq_port #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter logic [AW-1:0] DATA_OFS = 3'd3,
  parameter logic [AW-1:0] CTRL_OFS = 3'd4,
  parameter logic [AW-1:0] ACK_OFS  = 3'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_oe,
  output logic [DW-1:0] pin_out,
  input  logic          irq_in,
  output logic          irq_out
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] out_q;
  logic          lo_dir_q, hi_dir_q, int_en_q, intreq_q;
  logic [2:0]    sync_q;
  logic          fall, ack;

  assign pin_oe  = {{(DW-HALF){hi_dir_q}}, {HALF{lo_dir_q}}};
  assign pin_out = out_q;
  assign fall    = sync_q[2] & ~sync_q[1];
  assign ack     = rd_en && (addr == ACK_OFS);
  assign irq_out = intreq_q & int_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q    <= '0;
      lo_dir_q <= 1'b0;
      hi_dir_q <= 1'b0;
      int_en_q <= 1'b0;
      intreq_q <= 1'b0;
      sync_q   <= 3'b111;
    end else begin
      sync_q <= {sync_q[1:0], irq_in};
      if (wr_en && addr == DATA_OFS)
        out_q <= (wdata & pin_oe) | (out_q & ~pin_oe);
      if (wr_en && addr == CTRL_OFS) begin
        lo_dir_q <= wdata[0];
        hi_dir_q <= wdata[1];
        int_en_q <= wdata[2];
      end
      if (fall && int_en_q)
        intreq_q <= 1'b1;
      else if (ack)
        intreq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == DATA_OFS)
      rdata = (pin_in & ~pin_oe) | (out_q & pin_oe);
    else if (addr == CTRL_OFS)
      rdata[3:0] = {intreq_q, int_en_q, hi_dir_q, lo_dir_q};
  end
endmodule

module dio_irq_port_chk #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd_en,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] pin_in,
  input logic [DW-1:0] pin_oe,
  input logic [DW-1:0] pin_out,
  input logic          irq_out,
  input logic          intreq,
  input logic          int_en
);
  a_r2_input_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

  a_r3_mixed_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd3) |-> (rdata == ((pin_in & ~pin_oe) | (pin_out & pin_oe))));

  a_r5_nibble_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe[3:0] == {4{pin_oe[0]}}) && (pin_oe[7:4] == {4{pin_oe[4]}}));

  a_r6_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intreq) |-> $past(int_en));

  a_r7_sticky_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (intreq && !(rd_en && addr == 3'd1)) |=> intreq);

  a_r9_line_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (intreq && int_en));
endmodule

bind dio_irq_port dio_irq_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rdata(rdata),
  .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq_out(irq_out),
  .intreq(intreq_q), .int_en(int_en_q)
);

// File: tb/sim_dio_irq_port.sv
module sim_dio_irq_port;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] addr = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, pin_in = 0;
  logic [7:0] rdata, pin_oe, pin_out;
  logic       irq_in = 1;
  logic       irq_out;

  int checks = 0, errors = 0;
  logic [7:0] m_out = 0;
  logic       m_lo = 0, m_hi = 0, m_en = 0;
  logic [7:0] rd;
  int unsigned seed = 32'd1234;

  always #10 clk = ~clk;

  dio_irq_port u0 (.*);

  function automatic logic [7:0] exp_oe(logic lo, logic hi);
    return {{4{hi}}, {4{lo}}};
  endfunction

  function automatic logic [7:0] exp_mix(logic [7:0] pins, logic [7:0] drv, logic [7:0] oe);
    return (pins & ~oe) | (drv & oe);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rdx(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'h00);
    chk("R1 irq", {7'b0, irq_out}, 8'h00);
    rdx(3'd4, rd); chk("R1 ctrl", rd, 8'h00);

    // R2: all inputs, write ignored
    wr(3'd3, 8'hFF); @(negedge clk); chk("R2 all-input write", pin_out, 8'h00);
    wr(3'd4, 8'h01); m_lo = 1;
    chk("R5 low nibble", pin_oe, 8'h0F);
    wr(3'd3, 8'hA5); m_out = 8'h05; @(negedge clk);
    chk("R2 low only", pin_out, 8'h05);
    wr(3'd4, 8'h02); m_lo = 0; m_hi = 1;
    chk("R5 high nibble", pin_oe, 8'hF0);
    pin_in = 8'h3C; rdx(3'd3, rd); chk("R3 mixed", rd, 8'h0C);

    // R7: bit3 write cannot set flag
    wr(3'd4, 8'hFF); m_lo = 1; m_hi = 1; m_en = 1;
    rdx(3'd4, rd); chk("R4/R7 bit3 not writable", rd, 8'h07);

    // random data/control traffic, irq_in idle high
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [7:0] d;
      op = $urandom_range(0, 3);
      d  = 8'($urandom);
      case (op)
        0: begin wr(3'd3, d); m_out = (d & exp_oe(m_lo, m_hi)) | (m_out & ~exp_oe(m_lo, m_hi)); end
        1: begin wr(3'd4, d); m_lo = d[0]; m_hi = d[1]; m_en = d[2]; end
        2: pin_in = d;
        default: ;
      endcase
      @(negedge clk);
      chk("R5 oe", pin_oe, exp_oe(m_lo, m_hi));
      chk("R2 out", pin_out, m_out);
      rdx(3'd3, rd); chk("R3 read", rd, exp_mix(pin_in, m_out, exp_oe(m_lo, m_hi)));
      rdx(3'd4, rd); chk("R4 ctrl", rd, {5'b0, 1'b0, m_en, m_hi, m_lo} | 8'h00);
    end

    // R6: edge while disabled does not set
    wr(3'd4, 8'h00); m_en = 0;
    irq_in = 0; wait_cyc(5); irq_in = 1; wait_cyc(4);
    rdx(3'd4, rd); chk("R6 disabled edge", rd, 8'h00);

    // R6: enabled falling edge, latency three edges
    wr(3'd4, 8'h04); m_en = 1;
    @(negedge clk); irq_in = 0;
    @(posedge clk); @(posedge clk); #1;
    chk("R6 not yet after two edges", {7'b0, irq_out}, 8'h00);
    @(posedge clk); #1;
    chk("R6/R9 set on third edge", {7'b0, irq_out}, 8'h01);
    rdx(3'd4, rd); chk("R6 flag bit3", rd, 8'h0C);
    wr(3'd4, 8'h00);
    @(negedge clk); chk("R9 masked line", {7'b0, irq_out}, 8'h00);
    rdx(3'd4, rd); chk("R7 write keeps flag", rd, 8'h08);
    wr(3'd4, 8'h04);
    rdx(3'd1, rd); @(negedge clk);
    rdx(3'd4, rd); chk("R7 ack clears", rd, 8'h04);
    chk("R9 low after ack", {7'b0, irq_out}, 8'h00);

    // R6: rising edge does not set
    irq_in = 1; wait_cyc(5);
    rdx(3'd4, rd); chk("R6 rising edge", rd, 8'h04);

    // R8: edge coincides with clearing read
    wr(3'd4, 8'h04);
    @(negedge clk); irq_in = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 3'd1; rd_en = 1;
    @(posedge clk); #1 rd_en = 0;
    rdx(3'd4, rd); chk("R8 edge beats ack", rd, 8'h0C);
    chk("R8/R9 line", {7'b0, irq_out}, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule